// File: doc/BRIEF.md
# Priority-Interleaved ADC Sweep Sequencer

This block drives a multi-channel analog-to-digital converter in continuous sweep. A small group of priority channels, always starting at input 0, is converted in ascending order before every ordinary channel. With only input 0 in the group, the order is 0,1,0,2,0,3 and so on. With inputs 0 and 1 in the group, it is 0,1,2,0,1,3 and so on up to input 7, and then the sweep wraps around. An optional extended input can join the sweep as one more ordinary slot after input 7.

Conversions use a one-cycle start pulse and a done strobe that carries the data. Each completed conversion is stored in a result register for its channel, and any register can be read at any time through a read port. A clock-enable divider paces the starts. The control fields arrive as level inputs: run flag, start source, priority-group size, resolution, divider select and extended-input select. If any control field changes while a sweep is active, the sweep starts again from input 0. No interrupt is produced.

Top module: `emph_sweep_seq`

## Requirements
- R1: With `emph_sel_i`=00 the issued channel order is 0,1,0,2,...,0,7, then it wraps to 0,1.
- R2: `emph_sel_i`=k makes channels 0..k the priority group. The whole group is issued in ascending order before each ordinary channel k+1..7 in turn.
- R3: With `run_i`=1 (software start) sweeping starts and repeats until `run_i` goes to 0. No start is issued while `run_i`=0. A conversion already in flight still completes and is stored.
- R4: With `trig_sel_i`=1 sweeping begins only after a falling edge of `ext_trig_i`, seen through a two-flop synchronizer while `run_i`=1. Once begun, it continues until `run_i`=0. With `trig_sel_i`=0 it begins at once.
- R5: `conv_tick_o` is high every cycle when `clk_sel_i[1]`=1. Otherwise it is high every 2nd cycle (`clk_sel_i[0]`=1) or every 4th cycle (`clk_sel_i[0]`=0), counted from reset. A start is only issued in a tick cycle.
- R6: Each of channels 0..9 has its own result register. All registers reset to 0. Each is written when a valid conversion of that channel completes, and `rd_data_o` shows the register selected by `rd_chan_i` in the same cycle.
- R7: With `res10_i`=1 the full 10-bit value is stored. With `res10_i`=0 the stored value is the 10-bit data shifted right by 2, so the upper two bits are 0.
- R8: `ext_sel_i`=01 adds channel 8 and `ext_sel_i`=10 adds channel 9 as an ordinary slot after channel 7. Both 00 and 11 add nothing.
- R9: A change of any of `trig_sel_i`, `emph_sel_i`, `res10_i`, `clk_sel_i` or `ext_sel_i` makes the next issued channel 0. It also discards the result of the conversion in flight, including one that completes in the cycle the change is seen.
- R10: Each start is a single-cycle pulse, and no further start is issued until `conv_done_i` has returned for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start flag: 1 sweeps, 0 stops |
| trig_sel_i | input | 1 | 0 software start, 1 wait for external falling edge |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| emph_sel_i | input | 2 | Priority group is channels 0..emph_sel_i |
| res10_i | input | 1 | 1 stores 10-bit results, 0 stores 8-bit |
| clk_sel_i | input | 2 | Conversion clock-enable rate select |
| ext_sel_i | input | 2 | Extended input select |
| conv_tick_o | output | 1 | Divided conversion clock enable |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_chan_o | output | 4 | Channel to convert, valid with the start |
| conv_done_i | input | 1 | Conversion complete, data valid |
| conv_data_i | input | 10 | Conversion data |
| rd_chan_i | input | 4 | Result register select |
| rd_data_o | output | 10 | Selected result register |

## Verification
The collision that matters is a control-field rewrite seen in the same cycle as a conversion's done strobe. There the store must be dropped and the slot pointer must return to channel 0 at once. The bench provokes it by watching its converter stand-in count down, and it flips the resolution bit exactly when the done strobe is one cycle away. A queue-based reference model judges each case: it rebuilds the expected sweep from the current fields and compares every start, channel, tick and read-back value on every clock. So a stray write or a wrong resume point shows up as a miscompare.

// File: rtl/emph_pkg.sv
package emph_pkg;

  localparam int unsigned N_AIN   = 8;
  localparam int unsigned N_EXT   = 2;
  localparam int unsigned N_CH    = N_AIN + N_EXT;
  localparam int unsigned CH_W    = $clog2(N_CH);
  localparam int unsigned DW      = 10;
  localparam int unsigned NARROW  = 2;
  localparam int unsigned DIV_W   = 2;
  localparam int unsigned CFG_W   = 8;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_BUSY  = 2'd2
  } sq_state_e;

  function automatic logic [CH_W-1:0] prio_count(input logic [1:0] sel);
    return CH_W'(sel) + CH_W'(1);
  endfunction

  function automatic logic ext_on(input logic [1:0] sel);
    return (sel == 2'b01) || (sel == 2'b10);
  endfunction

  function automatic logic [CH_W-1:0] ext_chan(input logic [1:0] sel);
    return (sel == 2'b10) ? CH_W'(N_AIN + 1) : CH_W'(N_AIN);
  endfunction

  function automatic logic [CH_W-1:0] last_ordinary(input logic [CH_W-1:0] pcnt,
                                                    input logic [1:0] sel);
    logic [CH_W-1:0] r;
    r = CH_W'(N_AIN - 1) - pcnt;
    if (ext_on(sel)) r = r + CH_W'(1);
    return r;
  endfunction

  function automatic logic [CH_W-1:0] slot_chan(input logic [CH_W-1:0] pidx,
                                                input logic [CH_W-1:0] nidx,
                                                input logic [CH_W-1:0] pcnt,
                                                input logic [1:0]      sel);
    logic [CH_W-1:0] ord;
    ord = pcnt + nidx;
    if (pidx < pcnt)                  return pidx;
    else if (ord < CH_W'(N_AIN))      return ord;
    else                              return ext_chan(sel);
  endfunction

  function automatic logic [DW-1:0] scale_result(input logic [DW-1:0] d,
                                                 input logic wide);
    return wide ? d : (d >> NARROW);
  endfunction

  function automatic logic div_tick(input logic [DIV_W-1:0] cnt,
                                    input logic [1:0] sel);
    if (sel[1])      return 1'b1;
    else if (sel[0]) return cnt[0];
    else             return &cnt;
  endfunction

endpackage

// File: rtl/emph_clkdiv.sv
module emph_clkdiv
  import emph_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tick = div_tick(cnt, sel);

endmodule

// File: rtl/emph_trig_sync.sv
module emph_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];

endmodule

// File: rtl/emph_result_bank.sv
module emph_result_bank
  import emph_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CH_W-1:0] wch,
  input  logic [DW-1:0]   wd,
  input  logic [CH_W-1:0] rch,
  output logic [DW-1:0]   rd
);

  logic [DW-1:0] regs [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (we && wch == CH_W'(g))      regs[g] <= wd;
    end
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (rch == CH_W'(i)) rd = regs[i];
    end
  end

endmodule

// File: rtl/emph_sweep_seq.sv
module emph_sweep_seq
  import emph_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            trig_sel_i,
  input  logic            ext_trig_i,
  input  logic [1:0]      emph_sel_i,
  input  logic            res10_i,
  input  logic [1:0]      clk_sel_i,
  input  logic [1:0]      ext_sel_i,
  output logic            conv_tick_o,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_chan_o,
  input  logic            conv_done_i,
  input  logic [DW-1:0]   conv_data_i,
  input  logic [CH_W-1:0] rd_chan_i,
  output logic [DW-1:0]   rd_data_o
);

  sq_state_e       state;
  logic [CH_W-1:0] pidx, nidx, cur_chan;
  logic [CH_W-1:0] pcnt, slot_ch, nxt_pidx, nxt_nidx;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic            cfg_chg, restart;
  logic            armed, trig_fall, tick, active;
  logic            issue, accept, inflight_ok, in_flight, wr_en;
  logic [DW-1:0]   wr_data;

  emph_clkdiv u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (clk_sel_i),
    .tick  (tick)
  );

  emph_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_trig_i),
    .fall  (trig_fall)
  );

  emph_result_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .wch   (cur_chan),
    .wd    (wr_data),
    .rch   (rd_chan_i),
    .rd    (rd_data_o)
  );

  // control field snapshot and change detect
  assign cfg_now = {trig_sel_i, emph_sel_i, res10_i, clk_sel_i, ext_sel_i};
  assign cfg_chg = (cfg_now != cfg_q);
  assign restart = cfg_chg && (state != SQ_IDLE);

  // slot arithmetic
  assign pcnt    = prio_count(emph_sel_i);
  assign slot_ch = slot_chan(pidx, nidx, pcnt, ext_sel_i);

  always_comb begin
    nxt_pidx = pidx;
    nxt_nidx = nidx;
    if (pidx < pcnt) begin
      nxt_pidx = pidx + 1'b1;
    end else begin
      nxt_pidx = '0;
      nxt_nidx = (nidx >= last_ordinary(pcnt, ext_sel_i)) ? '0 : nidx + 1'b1;
    end
  end

  // event wires
  assign active    = run_i && (!trig_sel_i || armed);
  assign in_flight = (state == SQ_BUSY);
  assign issue     = (state == SQ_ISSUE) && tick && active && !cfg_chg;
  assign accept    = in_flight && conv_done_i;
  assign wr_en     = accept && inflight_ok && !cfg_chg;
  assign wr_data   = scale_result(conv_data_i, res10_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (!run_i)                        armed <= 1'b0;
      else if (trig_sel_i && trig_fall)  armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      pidx        <= '0;
      nidx        <= '0;
      cur_chan    <= '0;
      inflight_ok <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          pidx <= '0;
          nidx <= '0;
          if (active) state <= SQ_ISSUE;
        end
        SQ_ISSUE: begin
          if (!active) begin
            state <= SQ_IDLE;
            pidx  <= '0;
            nidx  <= '0;
          end else if (restart) begin
            pidx <= '0;
            nidx <= '0;
          end else if (issue) begin
            state       <= SQ_BUSY;
            cur_chan    <= slot_ch;
            inflight_ok <= 1'b1;
            pidx        <= nxt_pidx;
            nidx        <= nxt_nidx;
          end
        end
        SQ_BUSY: begin
          if (restart) begin
            inflight_ok <= 1'b0;
            pidx        <= '0;
            nidx        <= '0;
          end
          if (accept) state <= active ? SQ_ISSUE : SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign conv_tick_o  = tick;
  assign conv_start_o = issue;
  assign conv_chan_o  = slot_ch;

endmodule

// File: rtl/emph_sweep_chk.sv
module emph_sweep_chk
  import emph_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            run_i,
  input logic            res10_i,
  input logic            conv_start_o,
  input logic            conv_tick_o,
  input logic [CH_W-1:0] conv_chan_o,
  input logic            cfg_chg,
  input logic            in_flight,
  input logic            wr_en,
  input logic [DW-1:0]   wr_data
);

  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> conv_tick_o);  // R5

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> (!conv_start_o && in_flight));  // R10

  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (conv_chan_o == '0));  // R9

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !conv_start_o);  // R3

  AST_NARROW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !res10_i) |-> (wr_data[DW-1 -: NARROW] == '0));  // R7

endmodule

bind emph_sweep_seq emph_sweep_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_i        (run_i),
  .res10_i      (res10_i),
  .conv_start_o (conv_start_o),
  .conv_tick_o  (conv_tick_o),
  .conv_chan_o  (conv_chan_o),
  .cfg_chg      (cfg_chg),
  .in_flight    (in_flight),
  .wr_en        (wr_en),
  .wr_data      (wr_data)
);

// File: tb/sim_emph_sweep_seq.sv
`timescale 1ns/1ps
module sim_emph_sweep_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0, tsel = 1'b0, trig = 1'b0, res10 = 1'b1;
  logic [1:0] emph = 2'b00, csel = 2'b10, xsel = 2'b00;
  logic       done = 1'b0;
  logic [9:0] data = '0;
  logic [3:0] rch = '0;
  logic       tick_o, start_o;
  logic [3:0] chan_o;
  logic [9:0] rdata_o;

  always #10 clk = ~clk;  // 50 MHz

  emph_sweep_seq u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .trig_sel_i(tsel), .ext_trig_i(trig),
    .emph_sel_i(emph), .res10_i(res10), .clk_sel_i(csel), .ext_sel_i(xsel),
    .conv_tick_o(tick_o), .conv_start_o(start_o), .conv_chan_o(chan_o),
    .conv_done_i(done), .conv_data_i(data), .rd_chan_i(rch), .rd_data_o(rdata_o)
  );

  int vectors = 0, miscomp = 0;

  // ---------------- reference model ----------------
  int seq[$];
  int m_st = 0, m_pos = 0, m_cur = 0, m_cyc = 0;
  bit m_ok = 0, m_armed = 0, ms1 = 0, ms2 = 0, ms3 = 0;
  int m_cfgq = 0;
  int m_res[10];

  function automatic int cfg_word();
    return {tsel, emph, res10, csel, xsel};
  endfunction

  function automatic void build_seq();
    int p = emph + 1;
    int top = 8 + ((xsel == 2'b01 || xsel == 2'b10) ? 1 : 0);
    seq.delete();
    for (int n = p; n < top; n++) begin
      for (int k = 0; k < p; k++) seq.push_back(k);
      seq.push_back(n < 8 ? n : (xsel == 2'b10 ? 9 : 8));
    end
  endfunction

  function automatic bit exp_tick();
    int div = csel[0] ? 2 : 4;
    if (csel[1]) return 1'b1;
    return (m_cyc % div) == div - 1;
  endfunction

  function automatic bit exp_active();
    return run && (!tsel || m_armed);
  endfunction

  initial foreach (m_res[i]) m_res[i] = 0;

  initial forever begin
    @(posedge clk);
    if (!rst_n) begin
      m_st = 0; m_pos = 0; m_cur = 0; m_cyc = 0; m_ok = 0; m_armed = 0;
      ms1 = 0; ms2 = 0; ms3 = 0; m_cfgq = 0;
      foreach (m_res[i]) m_res[i] = 0;
    end else begin
      bit tk, fl, act, chg;
      build_seq();
      tk  = exp_tick();
      fl  = ms3 && !ms2;
      act = exp_active();
      chg = (cfg_word() != m_cfgq);
      if (m_st == 2 && done && m_ok && !chg)
        m_res[m_cur] = res10 ? int'(data) : int'(data) / 4;
      case (m_st)
        0: begin m_pos = 0; if (act) m_st = 1; end
        1: begin
          if (!act) begin m_st = 0; m_pos = 0; end
          else if (chg) m_pos = 0;
          else if (tk) begin
            m_st = 2; m_cur = seq[m_pos]; m_ok = 1;
            m_pos = (m_pos + 1) % seq.size();
          end
        end
        default: begin
          if (chg) begin m_ok = 0; m_pos = 0; end
          if (done) m_st = act ? 1 : 0;
        end
      endcase
      if (!run) m_armed = 0;
      else if (tsel && fl) m_armed = 1;
      ms3 = ms2; ms2 = ms1; ms1 = trig;
      m_cfgq = cfg_word();
      m_cyc++;
    end
  end

  // ---------------- compare and converter stand-in ----------------
  bit c_busy = 0;
  int c_cnt = 0, c_ch = 0, c_serial = 0;

  task automatic fail(string req, string what, int act_v, int exp_v);
    miscomp++;
    $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act_v, exp_v, $time);
  endtask

  initial forever begin
    @(negedge clk);
    begin
      bit e_start;
      build_seq();
      e_start = rst_n && m_st == 1 && exp_tick() && exp_active() && (cfg_word() == m_cfgq);
      vectors++;
      if (rst_n && tick_o !== exp_tick()) fail("R5", "tick", tick_o, exp_tick());
      if (start_o !== e_start) fail("R10", "start", start_o, e_start);  // also R3, R4
      if (e_start && start_o && int'(chan_o) != seq[m_pos])
        fail("R2", "channel", chan_o, seq[m_pos]);  // also R1, R8, R9
      if (int'(rdata_o) != m_res[rch]) fail("R6", "result", rdata_o, m_res[rch]);  // also R7
    end
    if (done) done = 1'b0;
    if (c_busy) begin
      c_cnt--;
      if (c_cnt == 0) begin
        done = 1'b1;
        data = 10'((c_ch * 131 + c_serial * 37) % 1024);
        c_serial++;
        c_busy = 0;
      end
    end else if (start_o) begin
      c_busy = 1; c_cnt = 3; c_ch = chan_o;
    end
    rch = (rch == 4'd9) ? 4'd0 : rch + 4'd1;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);                                   // R6 reset values compared
    // R1: single priority channel, full-rate enable
    run = 1; step(200);
    // R2, R7: two priority channels, 8-bit, divide by 2
    emph = 2'b01; res10 = 0; csel = 2'b01; step(300);
    // R2, R8: four priority channels, extended input 0, divide by 4
    emph = 2'b11; res10 = 1; csel = 2'b00; xsel = 2'b01; step(400);
    // R8: extended input 1, then the inhibited code
    emph = 2'b10; csel = 2'b10; xsel = 2'b10; step(250);
    xsel = 2'b11; step(150);
    xsel = 2'b00; emph = 2'b00;
    // R9: rewrite coinciding with a done strobe
    for (int i = 0; i < 6; i++) begin
      do step(1); while (!(c_busy && c_cnt == 1));
      res10 = ~res10;
      step(7);
    end
    // R9: rewrite in the middle of a conversion
    for (int i = 0; i < 4; i++) begin
      do step(1); while (!c_busy);
      emph = 2'(i);
      step(15);
    end
    // R3: stop during a conversion, stay quiet
    do step(1); while (!c_busy);
    run = 0; step(40);
    // R4: trigger edge while stopped does not arm
    tsel = 1; trig = 1; step(10); trig = 0; step(10);
    run = 1; step(30);
    // R4: falling edge with start flag set begins sweeping
    trig = 1; step(10); trig = 0; step(200);
    trig = 1; step(5); trig = 0; step(50);
    run = 0; step(30);
    // R4: software source starts at once
    tsel = 0; run = 1; step(100);
    run = 0; step(20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

endmodule